// File: doc/BRIEF.md
# Dual External Bus Steering Controller

This block sits between an internal master and two external buses, a primary bus and a calibration bus. Each request arrives through a valid/ready handshake and is matched against a set of address regions. Each region has a base, a compare mask, an enable, a bus-type flag and a wait-state count. A request that falls in a calibration-type region goes to the calibration bus. Every other request, including one that matches no region, goes to the primary bus. Only one bus carries a transfer at a time, and the target is chosen again for every access, so consecutive accesses can move between the buses.

A transfer begins in the cycle its request is accepted. In that cycle the block drives the start strobe for one clock, together with the address, the direction, the write data and the region's chip-select line. The block then ignores the acknowledge input for the region's configured number of wait states. It completes on the first acknowledge after that, captures the read data in the acknowledged cycle and returns a response one cycle later. An access that matches no region drives no chip-select. If no acknowledge arrives within a fixed window, it ends with an error response.

Chip-select changes need a turnaround. After a chip-select access, if the next access targets a different chip-select, or no chip-select at all, the block holds off one cycle before that access may start. The next access may also switch between the two buses. A repeat access to the same chip-select may start immediately. The grant input of the primary bus gates the start of an access on either bus, because the calibration bus has no arbitration signals of its own.

Top module: `dual_bus_steer`

## Requirements
- R1: An access whose address hits an enabled region with its calibration flag set raises `cal_ts` and bit i of `cal_cs`, where i is the region index. Any other access raises `pri_ts`, and a hit on a non-calibration region also raises bit i of `pri_cs`.
- R2: A region matches when it is enabled and `(addr ^ base) & mask` is zero. When several regions match, the one with the lowest index is used. A disabled region never matches.
- R3: The primary and calibration buses are never active in the same cycle. At most one start strobe and at most one chip-select bit across both buses are high.
- R4: A start strobe is high for exactly one clock, in the cycle the request is accepted. The target bus shows the request's address, direction and write data from that cycle until completion.
- R5: The acknowledge of the target bus is ignored during the first W cycles after the start cycle, where W is the region's 4-bit wait count. The access completes on the first acknowledge after that. The data of the acknowledged cycle appears on `rsp_rdata`, and `rsp_valid` (with `rsp_err` low) is high in the following cycle.
- R6: Two accesses to the same chip-select may run back to back. The second one may start in the cycle in which the first one's response is valid.
- R7: After a chip-select access, if the next access uses a different chip-select or none at all, exactly one cycle passes with no chip-select and no start strobe. This holds whether the next access stays on the same bus or switches buses.
- R8: An address that matches no region starts on the primary bus with no chip-select and zero wait states. If no acknowledge arrives within TIMEOUT cycles after the start cycle, the access ends with `rsp_valid` and `rsp_err` high.
- R9: While `bus_grant` is low, `req_ready` is low and no access starts on either bus.
- R10: After reset, `req_ready` follows `bus_grant`, and all start strobes, chip-selects and `rsp_valid` are low.
- R11: While an access is outstanding, `req_ready` stays low. A new request is accepted only in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | AW | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_rdata | output | DW | Read data of the completed access |
| rsp_err | output | 1 | Access timed out with no region match |
| cfg_base | input | NREG*AW | Region base addresses, region i at bits i*AW |
| cfg_mask | input | NREG*AW | Region compare masks, 1 = bit compared |
| cfg_en | input | NREG | Region enables |
| cfg_cal | input | NREG | Region targets the calibration bus |
| cfg_wait | input | NREG*WSW | Region wait-state counts |
| bus_grant | input | 1 | Primary bus grant, gates both buses |
| pri_ts | output | 1 | Primary start strobe |
| pri_cs | output | NREG | Primary chip-selects, active high |
| pri_addr | output | AW | Primary address |
| pri_we | output | 1 | Primary direction |
| pri_wdata | output | DW | Primary write data |
| pri_ta | input | 1 | Primary acknowledge |
| pri_rdata | input | DW | Primary read data |
| cal_ts | output | 1 | Calibration start strobe |
| cal_cs | output | NREG | Calibration chip-selects, active high |
| cal_addr | output | AW | Calibration address |
| cal_we | output | 1 | Calibration direction |
| cal_wdata | output | DW | Calibration write data |
| cal_ta | input | 1 | Calibration acknowledge |
| cal_rdata | input | DW | Calibration read data |

## Verification
The assertions check on every cycle that the two buses never carry a strobe or chip-select together, that start strobes last one clock and only with grant, and that the handshake is closed while an access is outstanding. They also check that a chip-select never hands directly to a different chip-select in the next cycle. The bench scenarios cover the rest: how long acknowledges are ignored, the latency on early and late acknowledges, region priority and disabling, the timeout error, and the exact turnaround counts for same-select, cross-select, cross-bus and select-to-no-select sequences.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } dbs_state_e;
endpackage

// File: rtl/dbs_region_match.sv
module dbs_region_match #(
   parameter int NREG = 4,
   parameter int AW   = 32,
   parameter int IW   = 2
) (
   input  logic [AW-1:0]      addr,
   input  logic [NREG*AW-1:0] cfg_base,
   input  logic [NREG*AW-1:0] cfg_mask,
   input  logic [NREG-1:0]    cfg_en,
   output logic               hit,
   output logic [IW-1:0]      idx
);
   logic [NREG-1:0] m;

   for (genvar i = 0; i < NREG; i++) begin : g_cmp
      assign m[i] = cfg_en[i] &&
         (((addr ^ cfg_base[i*AW +: AW]) & cfg_mask[i*AW +: AW]) == '0);
   end

   // lowest index wins: scan from the top so lower indices overwrite
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (m[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/dbs_wait_timer.sv
module dbs_wait_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          run,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clear)                  cnt <= '0;
      else if (run && (cnt != '1))     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dual_bus_steer.sv
module dual_bus_steer
   import dbs_pkg::*;
#(
   parameter int NREG    = 4,
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int WSW     = 4,
   parameter int TIMEOUT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AW-1:0]      req_addr,
   input  logic               req_we,
   input  logic [DW-1:0]      req_wdata,
   output logic               rsp_valid,
   output logic [DW-1:0]      rsp_rdata,
   output logic               rsp_err,
   input  logic [NREG*AW-1:0] cfg_base,
   input  logic [NREG*AW-1:0] cfg_mask,
   input  logic [NREG-1:0]    cfg_en,
   input  logic [NREG-1:0]    cfg_cal,
   input  logic [NREG*WSW-1:0] cfg_wait,
   input  logic               bus_grant,
   output logic               pri_ts,
   output logic [NREG-1:0]    pri_cs,
   output logic [AW-1:0]      pri_addr,
   output logic               pri_we,
   output logic [DW-1:0]      pri_wdata,
   input  logic               pri_ta,
   input  logic [DW-1:0]      pri_rdata,
   output logic               cal_ts,
   output logic [NREG-1:0]    cal_cs,
   output logic [AW-1:0]      cal_addr,
   output logic               cal_we,
   output logic [DW-1:0]      cal_wdata,
   input  logic               cal_ta,
   input  logic [DW-1:0]      cal_rdata
);
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int TOW = $clog2(TIMEOUT + 1);
   localparam int CW  = ((WSW > TOW) ? WSW : TOW) + 1;

   if (NREG < 1)    begin : g_bad_nreg $error("NREG must be at least 1"); end
   if (AW < 8)      begin : g_bad_aw   $error("AW must be at least 8"); end
   if (DW < 8)      begin : g_bad_dw   $error("DW must be at least 8"); end
   if (WSW < 1)     begin : g_bad_wsw  $error("WSW must be at least 1"); end
   if (TIMEOUT < 2) begin : g_bad_to   $error("TIMEOUT must be at least 2"); end

   dbs_state_e    st;
   logic          dec_hit, dec_cal;
   logic [IW-1:0] dec_idx;
   logic [WSW-1:0] dec_ws;

   logic [AW-1:0]  a_addr;
   logic           a_we, a_hit, a_cal;
   logic [DW-1:0]  a_wdata;
   logic [IW-1:0]  a_idx;
   logic [WSW-1:0] a_ws;

   logic           last_hit, last_cal, fresh;
   logic [IW-1:0]  last_idx;
   logic [CW-1:0]  wcnt;

   logic idle, busy, take, same_key, need_dead;
   logic ta_sel, ack, tmo, done, on;
   logic [DW-1:0] rd_sel;

   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_wdata;
   logic          cur_we, cur_hit, cur_cal;
   logic [IW-1:0] cur_idx;

   dbs_region_match #(.NREG(NREG), .AW(AW), .IW(IW)) u_match (
      .addr(req_addr), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
      .cfg_en(cfg_en), .hit(dec_hit), .idx(dec_idx)
   );

   dbs_wait_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(take), .run(busy), .cnt(wcnt)
   );

   assign dec_cal = dec_hit && cfg_cal[dec_idx];
   assign dec_ws  = dec_hit ? cfg_wait[dec_idx*WSW +: WSW] : '0;

   // turnaround gate: first idle cycle after a chip-select access,
   // next access targeting another select (or none)
   assign same_key  = (dec_hit == last_hit) && (dec_cal == last_cal) &&
                      (dec_idx == last_idx);
   assign need_dead = fresh && last_hit && !same_key;

   assign idle      = (st == ST_IDLE);
   assign busy      = (st == ST_WAIT);
   assign req_ready = idle && bus_grant && !need_dead;
   assign take      = req_valid && req_ready;

   assign ta_sel = a_cal ? cal_ta : pri_ta;
   assign rd_sel = a_cal ? cal_rdata : pri_rdata;
   assign ack    = busy && ta_sel && (wcnt >= CW'(a_ws));
   assign tmo    = busy && !a_hit && !ta_sel && (wcnt == CW'(TIMEOUT - 1));
   assign done   = ack || tmo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         a_addr    <= '0;
         a_we      <= 1'b0;
         a_wdata   <= '0;
         a_hit     <= 1'b0;
         a_cal     <= 1'b0;
         a_idx     <= '0;
         a_ws      <= '0;
         last_hit  <= 1'b0;
         last_cal  <= 1'b0;
         last_idx  <= '0;
         fresh     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= done;
         if (done) begin
            st        <= ST_IDLE;
            rsp_rdata <= ack ? rd_sel : '0;
            rsp_err   <= !ack;
            last_hit  <= a_hit;
            last_cal  <= a_cal;
            last_idx  <= a_idx;
            fresh     <= 1'b1;
         end else if (take) begin
            st      <= ST_WAIT;
            a_addr  <= req_addr;
            a_we    <= req_we;
            a_wdata <= req_wdata;
            a_hit   <= dec_hit;
            a_cal   <= dec_cal;
            a_idx   <= dec_idx;
            a_ws    <= dec_ws;
            fresh   <= 1'b0;
         end else if (idle) begin
            fresh <= 1'b0;
         end
      end
   end

   // the start cycle drives straight from the request
   assign cur_addr  = take ? req_addr  : a_addr;
   assign cur_wdata = take ? req_wdata : a_wdata;
   assign cur_we    = take ? req_we    : a_we;
   assign cur_hit   = take ? dec_hit   : a_hit;
   assign cur_cal   = take ? dec_cal   : a_cal;
   assign cur_idx   = take ? dec_idx   : a_idx;
   assign on        = take || busy;

   assign pri_ts    = take && !dec_cal;
   assign cal_ts    = take &&  dec_cal;
   assign pri_addr  = (on && !cur_cal) ? cur_addr  : '0;
   assign pri_we    = on && !cur_cal && cur_we;
   assign pri_wdata = (on && !cur_cal) ? cur_wdata : '0;
   assign cal_addr  = (on && cur_cal)  ? cur_addr  : '0;
   assign cal_we    = on && cur_cal && cur_we;
   assign cal_wdata = (on && cur_cal)  ? cur_wdata : '0;

   for (genvar i = 0; i < NREG; i++) begin : g_cs
      assign pri_cs[i] = on && cur_hit && !cur_cal && (cur_idx == IW'(i));
      assign cal_cs[i] = on && cur_hit &&  cur_cal && (cur_idx == IW'(i));
   end
endmodule

// File: rtl/dual_bus_steer_chk.sv
module dual_bus_steer_chk #(
   parameter int NREG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            bus_grant,
   input logic            rsp_valid,
   input logic            pri_ts,
   input logic            cal_ts,
   input logic [NREG-1:0] pri_cs,
   input logic [NREG-1:0] cal_cs
);
   logic [2*NREG-1:0] cs_all;
   assign cs_all = {cal_cs, pri_cs};

   // R3: never both buses at once
   a_r3_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_ts && cal_ts) && $onehot0(cs_all));

   // R4: start strobes last one clock
   a_r4_pri_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pri_ts |=> !pri_ts);
   a_r4_cal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cal_ts |=> !cal_ts);

   // R9: no start without grant
   a_r9_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_grant |-> !(pri_ts || cal_ts));

   // R11: handshake closed in the cycle after a start
   a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_ts || cal_ts) |=> !req_ready);

   // R5: no response in the cycle after a start
   a_r5_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_ts || cal_ts) |=> !rsp_valid);

   // R7: a select never hands straight to a different select
   a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cs_all) && (|$past(cs_all))) |-> (cs_all == $past(cs_all)));
endmodule

bind dual_bus_steer dual_bus_steer_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_grant(bus_grant),
   .rsp_valid(rsp_valid), .pri_ts(pri_ts), .cal_ts(cal_ts),
   .pri_cs(pri_cs), .cal_cs(cal_cs)
);

// File: tb/dual_bus_steer_tb.sv
module dual_bus_steer_tb;
   localparam int NREG = 4, AW = 32, DW = 32, WSW = 4, TIMEOUT = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic req_valid = 1'b0, req_we = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic rsp_valid, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic [NREG*AW-1:0] cfg_base, cfg_mask;
   logic [NREG-1:0] cfg_en, cfg_cal;
   logic [NREG*WSW-1:0] cfg_wait;
   logic bus_grant = 1'b1;
   logic pri_ts, cal_ts, pri_we, cal_we;
   logic [NREG-1:0] pri_cs, cal_cs;
   logic [AW-1:0] pri_addr, cal_addr;
   logic [DW-1:0] pri_wdata, cal_wdata, pri_rdata, cal_rdata;
   logic pri_ta = 1'b0, cal_ta = 1'b0;

   dual_bus_steer #(.NREG(NREG), .AW(AW), .DW(DW), .WSW(WSW), .TIMEOUT(TIMEOUT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en), .cfg_cal(cfg_cal),
      .cfg_wait(cfg_wait), .bus_grant(bus_grant),
      .pri_ts(pri_ts), .pri_cs(pri_cs), .pri_addr(pri_addr), .pri_we(pri_we),
      .pri_wdata(pri_wdata), .pri_ta(pri_ta), .pri_rdata(pri_rdata),
      .cal_ts(cal_ts), .cal_cs(cal_cs), .cal_addr(cal_addr), .cal_we(cal_we),
      .cal_wdata(cal_wdata), .cal_ta(cal_ta), .cal_rdata(cal_rdata)
   );

   // regions: 0 primary 0x1xxxxxxx ws3, 1 primary 0x2xxxxxxx ws1,
   //          2 calibration 0x3xxxxxxx ws3, 3 calibration 0x11xxxxxx ws2
   initial begin
      cfg_base = {32'h1100_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
      cfg_mask = {32'hFF00_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000};
      cfg_en   = 4'b1111;
      cfg_cal  = 4'b1100;
      cfg_wait = {4'd2, 4'd3, 4'd1, 4'd3};
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // bus responders: acknowledge held from `delay` cycles after the strobe
   int p_delay = 1, c_delay = 1;
   logic p_en = 1'b1, c_en = 1'b1;
   logic p_busy = 1'b0, c_busy = 1'b0;
   int p_cnt = 0, c_cnt = 0;
   logic [AW-1:0] p_lat = '0, c_lat = '0;
   assign pri_rdata = p_lat ^ 32'hA5A5_A5A5;
   assign cal_rdata = c_lat ^ 32'h5A5A_5A5A;

   always @(negedge clk) begin
      if (rsp_valid) begin p_busy = 1'b0; pri_ta = 1'b0; c_busy = 1'b0; cal_ta = 1'b0; end
      if (pri_ts) begin
         p_busy = 1'b1; p_cnt = 0; pri_ta = 1'b0; p_lat = pri_addr;
      end else if (p_busy) begin
         p_cnt++; pri_ta = p_en && (p_cnt >= p_delay);
      end
      if (cal_ts) begin
         c_busy = 1'b1; c_cnt = 0; cal_ta = 1'b0; c_lat = cal_addr;
      end else if (c_busy) begin
         c_cnt++; cal_ta = c_en && (c_cnt >= c_delay);
      end
   end

   int checks = 0, fails = 0;
   logic finished = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // captured per access
   int g_ts, g_rsp, g_stall;
   logic g_pts, g_cts, g_we, g_err, g_ts_next, g_rdy_next, g_stall_cs;
   logic [NREG-1:0] g_pcs, g_ccs;
   logic [AW-1:0] g_addr;
   logic [DW-1:0] g_wd, g_rd;

   // called at a negedge; returns at the negedge after acceptance
   task automatic send(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
      req_addr = a; req_we = w; req_wdata = d; req_valid = 1'b1;
      g_stall = 0; g_stall_cs = 1'b0;
      forever begin
         #1;
         if (req_ready) break;
         g_stall++;
         if ((|pri_cs) || (|cal_cs) || pri_ts || cal_ts) g_stall_cs = 1'b1;
         @(negedge clk);
      end
      g_ts = cyc; g_pts = pri_ts; g_cts = cal_ts; g_pcs = pri_cs; g_ccs = cal_cs;
      g_addr = pri_ts ? pri_addr : cal_addr;
      g_we   = pri_ts ? pri_we : cal_we;
      g_wd   = pri_ts ? pri_wdata : cal_wdata;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      g_ts_next = pri_ts || cal_ts; g_rdy_next = req_ready;
   endtask

   task automatic wait_rsp();
      while (!rsp_valid) @(negedge clk);
      g_rsp = cyc; g_rd = rsp_rdata; g_err = rsp_err;
   endtask

   task automatic t_reset();
      chk("R10 ready after reset", req_ready, 1);
      chk("R10 no strobe", {pri_ts, cal_ts}, 0);
      chk("R10 no select", {pri_cs, cal_cs}, 0);
      chk("R10 no response", rsp_valid, 0);
   endtask

   task automatic t_primary_read();
      p_delay = 1;
      send(32'h1000_0040, 1'b0, '0);
      chk("R1 primary strobe", {g_pts, g_cts}, 2'b10);
      chk("R1 primary select", {g_pcs, g_ccs}, {4'b0001, 4'b0000});
      chk("R4 address on bus", g_addr, 32'h1000_0040);
      chk("R4 strobe one clock", g_ts_next, 0);
      chk("R11 ready low while busy", g_rdy_next, 0);
      wait_rsp();
      chk("R5 latency early ack ws3", g_rsp - g_ts, 5);
      chk("R5 read data", g_rd, 32'h1000_0040 ^ 32'hA5A5_A5A5);
      chk("R5 no error", g_err, 0);
      @(negedge clk);
   endtask

   task automatic t_cal_read();
      c_delay = 1;
      send(32'h3000_0080, 1'b0, '0);
      chk("R1 calibration strobe", {g_pts, g_cts}, 2'b01);
      chk("R1 calibration select", {g_pcs, g_ccs}, {4'b0000, 4'b0100});
      wait_rsp();
      chk("R5 calibration data", g_rd, 32'h3000_0080 ^ 32'h5A5A_5A5A);
      chk("R5 calibration latency", g_rsp - g_ts, 5);
      @(negedge clk);
   endtask

   task automatic t_late_ack();
      p_delay = 6;
      send(32'h1000_0100, 1'b0, '0);
      wait_rsp();
      chk("R5 latency late ack", g_rsp - g_ts, 7);
      p_delay = 1;
      @(negedge clk);
   endtask

   task automatic t_write();
      send(32'h2000_0010, 1'b1, 32'hCAFE_F00D);
      chk("R4 write direction", g_we, 1);
      chk("R4 write data", g_wd, 32'hCAFE_F00D);
      chk("R1 region1 select", g_pcs, 4'b0010);
      wait_rsp();
      chk("R5 ws1 latency", g_rsp - g_ts, 3);
      @(negedge clk);
   endtask

   // back-to-back pair; returns stall cycles before the second start
   task automatic pair(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                       input int exp_stall, input string tag);
      int t1;
      send(a1, 1'b0, '0);
      wait_rsp();
      t1 = g_rsp;
      send(a2, 1'b0, '0);
      chk(tag, g_ts - t1, exp_stall);
      chk({tag, " idle bus"}, g_stall_cs, 0);
      wait_rsp();
      @(negedge clk);
   endtask

   task automatic t_turnaround();
      p_delay = 1; c_delay = 1;
      pair(32'h1000_0000, 32'h1000_0004, 0, "R6 same select no gap");
      pair(32'h1000_0000, 32'h2000_0000, 1, "R7 primary select change");
      pair(32'h3000_0000, 32'h1000_0000, 1, "R7 calibration to primary");
      pair(32'h1000_0000, 32'h3000_0000, 1, "R7 primary to calibration");
      pair(32'h3000_0000, 32'h5000_0000, 1, "R7 calibration to no select");
      pair(32'h3000_0000, 32'h3000_0010, 0, "R6 same calibration select");
   endtask

   task automatic t_priority();
      send(32'h1100_0000, 1'b0, '0);
      chk("R2 lowest index wins", {g_pcs, g_ccs}, {4'b0001, 4'b0000});
      wait_rsp();
      @(negedge clk);
      cfg_en[0] = 1'b0;
      @(negedge clk);
      send(32'h1100_0000, 1'b0, '0);
      chk("R2 disabled region skipped", {g_pcs, g_ccs}, {4'b0000, 4'b1000});
      wait_rsp();
      chk("R2 ws2 latency", g_rsp - g_ts, 4);
      cfg_en[0] = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_nomatch();
      p_delay = 2;
      send(32'h5000_0000, 1'b0, '0);
      chk("R8 unmatched on primary", {g_pts, g_cts}, 2'b10);
      chk("R8 unmatched no select", {g_pcs, g_ccs}, 0);
      wait_rsp();
      chk("R8 unmatched ack latency", g_rsp - g_ts, 3);
      chk("R8 unmatched ack ok", g_err, 0);
      @(negedge clk);
      p_en = 1'b0;
      send(32'h6000_0000, 1'b0, '0);
      wait_rsp();
      chk("R8 timeout error", g_err, 1);
      chk("R8 timeout latency", g_rsp - g_ts, TIMEOUT + 1);
      p_en = 1'b1; p_delay = 1;
      @(negedge clk);
   endtask

   task automatic t_grant();
      logic seen;
      seen = 1'b0;
      bus_grant = 1'b0;
      req_addr = 32'h3000_0000; req_we = 1'b0; req_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         if (req_ready || pri_ts || cal_ts) seen = 1'b1;
         @(negedge clk);
      end
      chk("R9 no start without grant", seen, 0);
      req_valid = 1'b0;
      bus_grant = 1'b1;
      send(32'h3000_0000, 1'b0, '0);
      chk("R9 start after grant", g_cts, 1);
      wait_rsp();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_primary_read();
      t_cal_read();
      t_late_ack();
      t_write();
      t_turnaround();
      t_priority();
      t_nomatch();
      t_grant();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule